// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block drives the control points of a multicycle processor datapath that shares one memory and one ALU between fetching instructions and executing them. Each cycle a micro-PC addresses a sixteen-entry store of narrow, field-encoded microwords. Field decoders widen each microword into individual strobes and selects: ALU function, operand sources, immediate extension, register-file write, memory access, instruction-register load and the program-counter write controls.

A two-bit sequencing field in every microword picks the next micro-address. It can return to the fetch microword, step to the next address, or jump to the entry point of the routine for the current instruction. That entry point comes from a small dispatch table indexed by the six-bit opcode. The opcode is used only at the end of the decode microword. The zero flag stays in the datapath: the controller raises a conditional PC-write strobe and the datapath combines it with the flag.

Top module: `ucode_ctrl`

## Requirements
- R1: Synchronous reset forces the micro-PC to 0. While reset is high, and in the first cycle after it falls, the outputs show the fetch microword: memRead=1, iorD=0, irWrite=1, pcWrite=1, pcSource=0, aluSelA=0, aluSelB=00, aluOp=00 (add), and every other strobe is 0.
- R2: The cycle after fetch is decode: aluOp=00, aluSelA=0, aluSelB=10 (extended immediate shifted left by 2), extOp=1, and no write or memory strobe is active.
- R3: At the end of decode, the opcode selects the next micro-address: 000000 goes to 4 (R-type), 000100 to 3 (BEQ), 001101 to 6 (ORI), 100011 to 8 (LW) and 101011 to 11 (SW). Any other opcode goes to address 0 (fetch).
- R4: R-type runs for two cycles. In the execute cycle aluOp=10 (function code), aluSelA=1 (rs) and aluSelB=01 (rt). In the write-back cycle regWrite=1, regDst=1 and memToReg=0. Then the sequencer returns to fetch.
- R5: ORI runs for two cycles. In the execute cycle aluOp=11 (OR), aluSelA=1, aluSelB=11 and extOp=0 (zero extension). In the write-back cycle regWrite=1, regDst=0 and memToReg=0. Then fetch.
- R6: LW runs for three cycles. In the address cycle aluOp=00, aluSelA=1, aluSelB=11 and extOp=1. In the memory cycle memRead=1 and iorD=1. In the write-back cycle regWrite=1, memToReg=1 and regDst=0. Then fetch.
- R7: SW runs for two cycles. The address cycle is the same as for LW. In the next cycle memWrite=1 and iorD=1. Then fetch.
- R8: BEQ runs for one cycle: aluOp=01 (subtract), aluSelA=1, aluSelB=01, pcWriteCond=1, pcSource=1 and pcWrite=0. Then fetch.
- R9: Every routine ends with a return to the fetch microword, which in turn steps sequentially to decode.
- R10: memRead and memWrite are never both high. pcWrite and pcWriteCond are never both high. memToReg is high only together with regWrite.
- R11: Reset asserted in any microword, including decode, returns the sequencer to fetch on the next edge.
- R12: The opcode has no effect in any cycle other than decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| aluOp | output | 2 | ALU function: 00 add, 01 subtract, 10 function code, 11 OR |
| aluSelA | output | 1 | First ALU operand: 0 PC, 1 rs |
| aluSelB | output | 2 | Second ALU operand: 00 constant 4, 01 rt, 10 extended and shifted, 11 extended |
| extOp | output | 1 | Immediate extension: 1 sign, 0 zero |
| regWrite | output | 1 | Register file write enable |
| memToReg | output | 1 | Register write data: 1 memory, 0 ALU result |
| regDst | output | 1 | Destination register: 1 rd, 0 rt |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| iorD | output | 1 | Memory address: 0 PC, 1 ALU result register |
| irWrite | output | 1 | Instruction register load |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write qualified by the ALU zero flag |
| pcSource | output | 1 | PC source: 0 ALU output, 1 ALU result register |

## Verification
Two of the block's functions can claim the next micro-address in the same cycle: the opcode dispatch at the end of decode and a synchronous reset. The bench raises reset during a decode cycle while a valid R-type opcode is on the input. It expects the fetch microword on the next cycle, not the R-type execute microword, and expects decode one cycle after reset falls. In another test the opcode changes in the same cycles as fetch and as routine execution. The check is that only the value present during decode chooses the routine.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UADDR_W = 4;
  localparam int OP_W    = 6;

  typedef enum logic [1:0] {
    SEQ_FETCH    = 2'b00,
    SEQ_DISPATCH = 2'b01,
    SEQ_NEXT     = 2'b10,
    SEQ_RSVD     = 2'b11
  } seqSel_e;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;
  localparam logic [1:0] ALU_OR   = 2'b11;

  localparam logic       S1_PC = 1'b0;
  localparam logic       S1_RS = 1'b1;

  localparam logic [2:0] S2_NONE  = 3'b000;
  localparam logic [2:0] S2_FOUR  = 3'b001;
  localparam logic [2:0] S2_RT    = 3'b010;
  localparam logic [2:0] S2_EXTSH = 3'b011;
  localparam logic [2:0] S2_EXT   = 3'b100;
  localparam logic [2:0] S2_EXT0  = 3'b111;

  localparam logic [1:0] DST_NONE   = 2'b00;
  localparam logic [1:0] DST_RD_ALU = 2'b01;
  localparam logic [1:0] DST_RT_ALU = 2'b10;
  localparam logic [1:0] DST_RT_MEM = 2'b11;

  localparam logic [1:0] MEM_NONE   = 2'b00;
  localparam logic [1:0] MEM_RD_PC  = 2'b01;
  localparam logic [1:0] MEM_RD_ALU = 2'b10;
  localparam logic [1:0] MEM_WR_ALU = 2'b11;

  localparam logic [1:0] PCW_NONE = 2'b00;
  localparam logic [1:0] PCW_ALU  = 2'b01;
  localparam logic [1:0] PCW_COND = 2'b10;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

  localparam logic [UADDR_W-1:0] UA_FETCH  = 4'd0;
  localparam logic [UADDR_W-1:0] UA_DECODE = 4'd1;
  localparam logic [UADDR_W-1:0] UA_BEQ    = 4'd3;
  localparam logic [UADDR_W-1:0] UA_RTYPE  = 4'd4;
  localparam logic [UADDR_W-1:0] UA_ORI    = 4'd6;
  localparam logic [UADDR_W-1:0] UA_LW     = 4'd8;
  localparam logic [UADDR_W-1:0] UA_SW     = 4'd11;

  typedef struct packed {
    logic [1:0] aluF;
    logic       src1;
    logic [2:0] src2;
    logic [1:0] dest;
    logic [1:0] mem;
    logic       irLoad;
    logic [1:0] pcw;
    seqSel_e    seq;
  } uword_t;

  typedef struct packed {
    logic [1:0] aluOp;
    logic       aluSelA;
    logic [1:0] aluSelB;
    logic       extOp;
    logic       regWrite;
    logic       memToReg;
    logic       regDst;
    logic       memRead;
    logic       memWrite;
    logic       iorD;
    logic       irWrite;
    logic       pcWrite;
    logic       pcWriteCond;
    logic       pcSource;
  } ctrlStrobes_t;

  function automatic uword_t mkWord(logic [1:0] aluF, logic src1, logic [2:0] src2,
                                    logic [1:0] dest, logic [1:0] mem, logic irLoad,
                                    logic [1:0] pcw, seqSel_e seq);
    uword_t w;
    w.aluF = aluF; w.src1 = src1; w.src2 = src2; w.dest = dest;
    w.mem = mem; w.irLoad = irLoad; w.pcw = pcw; w.seq = seq;
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int ADDR_W = UADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  localparam int DEPTH = 1 << ADDR_W;

  always_comb begin
    word = mkWord(ALU_ADD, S1_PC, S2_NONE, DST_NONE, MEM_NONE, 1'b0, PCW_NONE, SEQ_FETCH);
    if (int'(addr) < DEPTH) begin
      case (int'(addr))
        0:  word = mkWord(ALU_ADD,  S1_PC, S2_FOUR,  DST_NONE,   MEM_RD_PC,  1'b1, PCW_ALU,  SEQ_NEXT);
        1:  word = mkWord(ALU_ADD,  S1_PC, S2_EXTSH, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_DISPATCH);
        3:  word = mkWord(ALU_SUB,  S1_RS, S2_RT,    DST_NONE,   MEM_NONE,   1'b0, PCW_COND, SEQ_FETCH);
        4:  word = mkWord(ALU_FUNC, S1_RS, S2_RT,    DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
        5:  word = mkWord(ALU_ADD,  S1_PC, S2_NONE,  DST_RD_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
        6:  word = mkWord(ALU_OR,   S1_RS, S2_EXT0,  DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
        7:  word = mkWord(ALU_ADD,  S1_PC, S2_NONE,  DST_RT_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
        8:  word = mkWord(ALU_ADD,  S1_RS, S2_EXT,   DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
        9:  word = mkWord(ALU_ADD,  S1_PC, S2_NONE,  DST_NONE,   MEM_RD_ALU, 1'b0, PCW_NONE, SEQ_NEXT);
        10: word = mkWord(ALU_ADD,  S1_PC, S2_NONE,  DST_RT_MEM, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
        11: word = mkWord(ALU_ADD,  S1_RS, S2_EXT,   DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
        12: word = mkWord(ALU_ADD,  S1_PC, S2_NONE,  DST_NONE,   MEM_WR_ALU, 1'b0, PCW_NONE, SEQ_FETCH);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OPC_W  = OP_W,
  parameter int ADDR_W = UADDR_W
) (
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] target
);
  always_comb begin
    case (opcode)
      OP_RTYPE: target = ADDR_W'(UA_RTYPE);
      OP_BEQ:   target = ADDR_W'(UA_BEQ);
      OP_ORI:   target = ADDR_W'(UA_ORI);
      OP_LW:    target = ADDR_W'(UA_LW);
      OP_SW:    target = ADDR_W'(UA_SW);
      default:  target = ADDR_W'(UA_FETCH);
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int ADDR_W = UADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seqSel_e           seq,
  input  logic [ADDR_W-1:0] dispTarget,
  output logic [ADDR_W-1:0] upc
);
  logic [ADDR_W-1:0] upcNext;

  always_comb begin
    case (seq)
      SEQ_NEXT:     upcNext = upc + 1'b1;
      SEQ_DISPATCH: upcNext = dispTarget;
      default:      upcNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upcNext;
  end
endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
  import ucode_pkg::*;
(
  input  uword_t       word,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.aluOp   = word.aluF;
    strobes.aluSelA = word.src1;

    case (word.src2)
      S2_FOUR:  begin strobes.aluSelB = 2'b00; strobes.extOp = 1'b0; end
      S2_RT:    begin strobes.aluSelB = 2'b01; strobes.extOp = 1'b0; end
      S2_EXTSH: begin strobes.aluSelB = 2'b10; strobes.extOp = 1'b1; end
      S2_EXT:   begin strobes.aluSelB = 2'b11; strobes.extOp = 1'b1; end
      S2_EXT0:  begin strobes.aluSelB = 2'b11; strobes.extOp = 1'b0; end
      default:  begin strobes.aluSelB = 2'b00; strobes.extOp = 1'b0; end
    endcase

    case (word.dest)
      DST_RD_ALU: begin strobes.regWrite = 1'b1; strobes.regDst = 1'b1; end
      DST_RT_ALU: strobes.regWrite = 1'b1;
      DST_RT_MEM: begin strobes.regWrite = 1'b1; strobes.memToReg = 1'b1; end
      default: ;
    endcase

    case (word.mem)
      MEM_RD_PC:  strobes.memRead = 1'b1;
      MEM_RD_ALU: begin strobes.memRead = 1'b1; strobes.iorD = 1'b1; end
      MEM_WR_ALU: begin strobes.memWrite = 1'b1; strobes.iorD = 1'b1; end
      default: ;
    endcase

    strobes.irWrite = word.irLoad;

    case (word.pcw)
      PCW_ALU:  strobes.pcWrite = 1'b1;
      PCW_COND: begin strobes.pcWriteCond = 1'b1; strobes.pcSource = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int ADDR_W = UADDR_W,
  parameter int OPC_W  = OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [1:0]       aluOp,
  output logic             aluSelA,
  output logic [1:0]       aluSelB,
  output logic             extOp,
  output logic             regWrite,
  output logic             memToReg,
  output logic             regDst,
  output logic             memRead,
  output logic             memWrite,
  output logic             iorD,
  output logic             irWrite,
  output logic             pcWrite,
  output logic             pcWriteCond,
  output logic             pcSource
);
  logic [ADDR_W-1:0] upc;
  logic [ADDR_W-1:0] dispTarget;
  uword_t            word;
  ctrlStrobes_t      strobes;

  ucode_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .seq(word.seq), .dispTarget(dispTarget), .upc(upc)
  );

  ucode_dispatch #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_disp (
    .opcode(opcode), .target(dispTarget)
  );

  ucode_rom #(.ADDR_W(ADDR_W)) u_rom (.addr(upc), .word(word));

  ucode_decode u_dec (.word(word), .strobes(strobes));

  assign aluOp       = strobes.aluOp;
  assign aluSelA     = strobes.aluSelA;
  assign aluSelB     = strobes.aluSelB;
  assign extOp       = strobes.extOp;
  assign regWrite    = strobes.regWrite;
  assign memToReg    = strobes.memToReg;
  assign regDst      = strobes.regDst;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign iorD        = strobes.iorD;
  assign irWrite     = strobes.irWrite;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign pcSource    = strobes.pcSource;
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] aluOp,
  input logic       aluSelA,
  input logic [1:0] aluSelB,
  input logic       extOp,
  input logic       regWrite,
  input logic       memToReg,
  input logic       memRead,
  input logic       memWrite,
  input logic       iorD,
  input logic       irWrite,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       pcSource
);
  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    rst |=> (irWrite && pcWrite && memRead && !iorD && !pcSource));

  assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (!irWrite && aluSelB == 2'b10 && extOp && !aluSelA
                 && !regWrite && !memRead && !memWrite));

  assert_writeback_returns_R9: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> irWrite);

  assert_load_writeback_R6: assert property (@(posedge clk) disable iff (rst)
    memToReg |-> $past(memRead && iorD));

  assert_store_address_R7: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> (iorD && $past(aluSelA && aluSelB == 2'b11 && extOp)));

  assert_branch_shape_R8: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |-> (aluOp == 2'b01 && pcSource && !pcWrite));

  assert_branch_returns_R8: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |=> irWrite);

  assert_mem_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRead, memWrite}) && $onehot0({pcWrite, pcWriteCond}));

  assert_memtoreg_gated_R10: assert property (@(posedge clk) disable iff (rst)
    memToReg |-> regWrite);
endmodule

bind ucode_ctrl ucode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .aluOp(aluOp), .aluSelA(aluSelA), .aluSelB(aluSelB),
  .extOp(extOp), .regWrite(regWrite), .memToReg(memToReg), .memRead(memRead),
  .memWrite(memWrite), .iorD(iorD), .irWrite(irWrite), .pcWrite(pcWrite),
  .pcWriteCond(pcWriteCond), .pcSource(pcSource)
);

// File: tb/ucode_ctrl_bench.sv
module ucode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [1:0] aluOp, aluSelB;
  logic aluSelA, extOp, regWrite, memToReg, regDst, memRead, memWrite;
  logic iorD, irWrite, pcWrite, pcWriteCond, pcSource;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ucode_ctrl u_ucode_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .aluOp(aluOp), .aluSelA(aluSelA),
    .aluSelB(aluSelB), .extOp(extOp), .regWrite(regWrite), .memToReg(memToReg),
    .regDst(regDst), .memRead(memRead), .memWrite(memWrite), .iorD(iorD),
    .irWrite(irWrite), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .pcSource(pcSource)
  );

  // Order: aluOp, aluSelA, aluSelB, extOp, regWrite, memToReg, regDst,
  //        memRead, memWrite, iorD, irWrite, pcWrite, pcWriteCond, pcSource
  localparam logic [15:0] V_FETCH  = 16'b00_0_00_0_0_0_0_1_0_0_1_1_0_0;
  localparam logic [15:0] V_DECODE = 16'b00_0_10_1_0_0_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_RX     = 16'b10_1_01_0_0_0_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_RWB    = 16'b00_0_00_0_1_0_1_0_0_0_0_0_0_0;
  localparam logic [15:0] V_OX     = 16'b11_1_11_0_0_0_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_OWB    = 16'b00_0_00_0_1_0_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_ADDR   = 16'b00_1_11_1_0_0_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_LMEM   = 16'b00_0_00_0_0_0_0_1_0_1_0_0_0_0;
  localparam logic [15:0] V_LWB    = 16'b00_0_00_0_1_1_0_0_0_0_0_0_0_0;
  localparam logic [15:0] V_SMEM   = 16'b00_0_00_0_0_0_0_0_1_1_0_0_0_0;
  localparam logic [15:0] V_BX     = 16'b01_1_01_0_0_0_0_0_0_0_0_0_1_1;

  function automatic logic [15:0] observed();
    return {aluOp, aluSelA, aluSelB, extOp, regWrite, memToReg, regDst,
            memRead, memWrite, iorD, irWrite, pcWrite, pcWriteCond, pcSource};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    logic [15:0] got = observed();
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // From fetch: runs fetch, decode, up to three routine cycles, then expects fetch.
  task automatic runRoutine(input string req, input logic [5:0] op, input int n,
                            input logic [15:0] v0, input logic [15:0] v1,
                            input logic [15:0] v2);
    check({req, " fetch R9"}, V_FETCH);
    opcode = op;
    step(); check({req, " decode R2"}, V_DECODE);
    if (n > 0) begin step(); check(req, v0); end
    if (n > 1) begin step(); check(req, v1); end
    if (n > 2) begin step(); check(req, v2); end
    step(); check({req, " return R9"}, V_FETCH);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) step();
    check("R1 during reset", V_FETCH);
    rst = 1'b0;
    check("R1 after reset", V_FETCH);
  endtask

  task automatic testRtype();  runRoutine("R4 R3", 6'b000000, 2, V_RX, V_RWB, '0);   endtask
  task automatic testOri();    runRoutine("R5 R3", 6'b001101, 2, V_OX, V_OWB, '0);   endtask
  task automatic testLw();     runRoutine("R6 R3", 6'b100011, 3, V_ADDR, V_LMEM, V_LWB); endtask
  task automatic testSw();     runRoutine("R7 R3", 6'b101011, 2, V_ADDR, V_SMEM, '0); endtask
  task automatic testBeq();    runRoutine("R8 R3", 6'b000100, 1, V_BX, '0, '0);      endtask
  task automatic testUnknown();
    runRoutine("R3 unknown opcode", 6'b111111, 0, '0, '0, '0);
    runRoutine("R3 near-miss opcode", 6'b100010, 0, '0, '0, '0);
  endtask

  // R12: opcode changes outside decode must not steer the sequence
  task automatic testOpcodeIgnored();
    check("R12 fetch", V_FETCH);
    opcode = 6'b000100;
    step(); check("R12 decode", V_DECODE);
    opcode = 6'b100011;
    step(); check("R12 lw address", V_ADDR);
    opcode = 6'b101011;
    step(); check("R12 lw memory", V_LMEM);
    opcode = 6'b000000;
    step(); check("R12 lw writeback", V_LWB);
    opcode = 6'b000100;
    step(); check("R12 fetch again", V_FETCH);
    opcode = 6'b001101;
    step(); check("R12 decode again", V_DECODE);
    step(); check("R12 ori selected at decode", V_OX);
    step(); check("R12 ori writeback", V_OWB);
    step(); check("R12 return", V_FETCH);
  endtask

  // R11: reset mid-routine and reset colliding with dispatch
  task automatic testResetMid();
    check("R11 fetch", V_FETCH);
    opcode = 6'b100011;
    step(); step(); step(); check("R11 lw memory", V_LMEM);
    rst = 1'b1;
    step(); check("R11 reset from memory cycle", V_FETCH);
    rst = 1'b0;
    step(); check("R11 decode after reset", V_DECODE);
    opcode = 6'b000000;
    rst = 1'b1;
    step(); check("R11 reset beats dispatch", V_FETCH);
    rst = 1'b0;
    step(); check("R11 decode after collision", V_DECODE);
    step(); check("R11 rtype after collision", V_RX);
    step(); check("R11 rtype writeback", V_RWB);
    step(); check("R11 return", V_FETCH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testRtype();
    testOri();
    testLw();
    testSw();
    testBeq();
    testUnknown();
    testOpcodeIgnored();
    testResetMid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule